// File: doc/BRIEF.md
# Channel Completion and Flush Tracker

This block collects end-of-transfer reports for a bank of DMA channels and presents them to software through a small register port. The transfer engine signals, per channel, that a command list ended normally or with an error. Each report becomes a result word that software reads to retire it. Each channel queues up to two reports: one that software can read and one held behind it. A result that arrives while both are occupied is folded into the held one as an overflow marker.

Software can abort a channel by writing its flush register. On a busy channel this sends a one-cycle abort pulse to the engine and always posts a flush result. On an idle channel it posts a flush result only when the channel's flush-report enable is set. Otherwise the write has no effect. Every channel has an interrupt enable. The single interrupt output is raised while any channel with its enable set has a result waiting. An aggregated status word shows every channel that has a result waiting, whatever its enable.

Top module: `cmpl_flush_tracker`

## Requirements
- R1: After reset no result is pending, every readable register returns 0, `irq` is low and `flush_req` is all zeros.
- R2: A pulse on `eng_done[i]` posts result word 0x80000002 (bit 31 valid, bit 1 normal end). A pulse on `eng_err[i]` posts 0x80000008 (bit 3 error). Both in the same cycle post 0x8000000A.
- R3: The channel status register at byte 0x200+4*i reads 0x2 (bit 1) while channel i has a result waiting, and 0 otherwise. The aggregated register at 0x380 has bit i set for each such channel.
- R4: A read of 0x40+4*i returns channel i's oldest result and removes it. When nothing else is queued, the status bit and the aggregated bit clear. A read of an empty channel returns 0.
- R5: The configuration register at 0x300+4*i holds bit 0 (interrupt enable) and bit 1 (flush-report enable). It resets to 0 and reads back only those two bits.
- R6: A write of any value to 0x80+4*i while `eng_busy[i]` is high pulses `flush_req[i]` for exactly the next cycle. It also posts result 0x80000004 (bit 2 flushed), whatever the flush-report enable.
- R7: A flush write to an idle channel posts 0x80000004 only when that channel's flush-report enable is set. Otherwise it leaves the channel's result and status unchanged. It never pulses `flush_req`.
- R8: A second result that arrives while one is unread is held back. It becomes readable after the first is read, so results are read in arrival order.
- R9: A result that arrives while both slots are full is not stored. Instead the held result gains bit 4 (overflow) and bit 3 (error), and keeps its other flags. The readable result does not change.
- R10: `irq` is high exactly while some channel has a result waiting and its interrupt enable is set. With the enable clear, a waiting result still shows in the aggregated register.
- R11: Writes to the result, channel status and aggregated registers change no state.
- R12: Events and register accesses on one channel leave every other channel's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of a result register pops it at the clock edge |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle `reg_rd` is high |
| eng_busy | input | NUM_CH | Channel has an active command list |
| eng_done | input | NUM_CH | Command list ended normally (one-cycle pulse) |
| eng_err | input | NUM_CH | Command list ended with error (one-cycle pulse) |
| flush_req | output | NUM_CH | Abort request to the engine, one cycle |
| irq | output | 1 | Interrupt, OR of enabled pending channels |

## Verification
A wrong slot state shows at the ports within one read. A lost held result shows as a 0 read where a second word was expected. A premature pop clears the aggregated bit and drops `irq` in the cycle after the read. Result words and the aggregated register are combinational views of the slot flops, so a bad flag or a swapped channel index is visible on `reg_rdata` in the same cycle as the read. A flush decoded to the wrong channel shows up one cycle later as a misplaced `flush_req` bit and a flush result on a channel that was not written.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;
   localparam int MAX_CH = 16;
   localparam int IDX_W  = 4;
   localparam int REG_LSB = 2 + IDX_W;

   localparam logic [5:0] RGN_RESULT = 6'h01;
   localparam logic [5:0] RGN_FLUSH  = 6'h02;
   localparam logic [5:0] RGN_STATUS = 6'h08;
   localparam logic [5:0] RGN_CFG    = 6'h0C;
   localparam logic [5:0] RGN_AGG    = 6'h0E;

   localparam int STAT_PEND_BIT = 1;

   typedef enum logic [2:0] {
      REG_NONE,
      REG_RESULT,
      REG_FLUSH,
      REG_STATUS,
      REG_CFG,
      REG_AGG
   } region_e;

   typedef struct packed {
      logic ovf;
      logic err;
      logic fl;
      logic tpd;
   } res_flags_t;

   function automatic logic [31:0] pack_result(input logic vld, input res_flags_t f);
      return {vld, 26'b0, f.ovf, f.err, f.fl, f.tpd, 1'b0};
   endfunction
endpackage

// File: rtl/cmpl_regdec.sv
module cmpl_regdec
   import cmpl_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int NUM_CH = 16
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic [IDX_W-1:0]  idx,
   output logic              ch_ok
);
   localparam int RGN_W = ADDR_W - REG_LSB;

   logic [RGN_W-1:0] rgn;
   logic             unused_lsb;

   assign idx        = addr[REG_LSB-1:2];
   assign rgn        = addr[ADDR_W-1:REG_LSB];
   assign unused_lsb = ^addr[1:0];

   always_comb begin
      region = REG_NONE;
      if (rgn == RGN_W'(RGN_RESULT))      region = REG_RESULT;
      else if (rgn == RGN_W'(RGN_FLUSH))  region = REG_FLUSH;
      else if (rgn == RGN_W'(RGN_STATUS)) region = REG_STATUS;
      else if (rgn == RGN_W'(RGN_CFG))    region = REG_CFG;
      else if (rgn == RGN_W'(RGN_AGG) && idx == '0) region = REG_AGG;
   end

   assign ch_ok = (int'(idx) < NUM_CH);
endmodule

// File: rtl/cmpl_chan_slot.sv
module cmpl_chan_slot
   import cmpl_pkg::*;
#(
   parameter bit USE_SHADOW = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       new_vld,
   input  res_flags_t new_flags,
   input  logic       pop,
   output logic       p_vld,
   output res_flags_t p_flags
);
   localparam res_flags_t OVF_MARK = '{ovf: 1'b1, err: 1'b1, fl: 1'b0, tpd: 1'b0};

   generate
      if (USE_SHADOW) begin : g_shadow
         logic       s_vld;
         res_flags_t s_flags;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               p_vld   <= 1'b0;
               p_flags <= '0;
               s_vld   <= 1'b0;
               s_flags <= '0;
            end else if (pop && p_vld) begin
               if (s_vld) begin
                  p_flags <= s_flags;
                  if (new_vld) s_flags <= new_flags;
                  else         s_vld   <= 1'b0;
               end else if (new_vld) begin
                  p_flags <= new_flags;
               end else begin
                  p_vld <= 1'b0;
               end
            end else if (new_vld) begin
               if (!p_vld) begin
                  p_vld   <= 1'b1;
                  p_flags <= new_flags;
               end else if (!s_vld) begin
                  s_vld   <= 1'b1;
                  s_flags <= new_flags;
               end else begin
                  s_flags <= s_flags | OVF_MARK;
               end
            end
         end

         // R8: the held slot is only occupied behind an occupied readable slot
         a_r8_shadow_behind_primary: assert property (@(posedge clk) disable iff (!rst_n)
            s_vld |-> p_vld);
         // R8: reading with a held result moves it forward
         a_r8_promote_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
            (pop && p_vld && s_vld) |=> p_vld);
         // R4: reading the last result empties the channel
         a_r4_pop_empties: assert property (@(posedge clk) disable iff (!rst_n)
            (pop && p_vld && !s_vld && !new_vld) |=> !p_vld);
         // R9: a result into a full queue marks overflow
         a_r9_overflow_marked: assert property (@(posedge clk) disable iff (!rst_n)
            (p_vld && s_vld && new_vld && !pop) |=> (s_flags.ovf && s_flags.err));
      end else begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               p_vld   <= 1'b0;
               p_flags <= '0;
            end else if (pop && p_vld) begin
               if (new_vld) p_flags <= new_flags;
               else         p_vld   <= 1'b0;
            end else if (new_vld) begin
               if (!p_vld) begin
                  p_vld   <= 1'b1;
                  p_flags <= new_flags;
               end else begin
                  p_flags <= p_flags | OVF_MARK;
               end
            end
         end

         // R4: reading the only result empties the channel
         a_r4_pop_empties_single: assert property (@(posedge clk) disable iff (!rst_n)
            (pop && p_vld && !new_vld) |=> !p_vld);
      end
   endgenerate
endmodule

// File: rtl/cmpl_irq_agg.sv
module cmpl_irq_agg #(
   parameter int NUM_CH  = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pend,
   input  logic [NUM_CH-1:0] ien,
   output logic              irq
);
   logic any_live;

   assign any_live = |(pend & ien);

   generate
      if (IRQ_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= any_live;
         end
      end else begin : g_comb
         assign irq = any_live;
      end
   endgenerate
endmodule

// File: rtl/cmpl_flush_tracker.sv
module cmpl_flush_tracker
   import cmpl_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int NUM_CH     = 16,
   parameter bit USE_SHADOW = 1'b1,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [NUM_CH-1:0] eng_busy,
   input  logic [NUM_CH-1:0] eng_done,
   input  logic [NUM_CH-1:0] eng_err,
   output logic [NUM_CH-1:0] flush_req,
   output logic              irq
);
   generate
      if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
         $error("cmpl_flush_tracker: NUM_CH must be 1..16");
      end
      if (ADDR_W < 12) begin : g_bad_aw
         $error("cmpl_flush_tracker: ADDR_W must be at least 12");
      end
   endgenerate

   region_e                   region;
   logic [IDX_W-1:0]          idx;
   logic                      ch_ok;
   logic [NUM_CH-1:0]         pend;
   logic [NUM_CH-1:0]         ien;
   logic [NUM_CH-1:0]         fen;
   logic [NUM_CH-1:0]         flush_hit;
   res_flags_t [NUM_CH-1:0]   res_flags;
   logic                      unused_wdata;

   assign unused_wdata = ^reg_wdata[31:2];

   cmpl_regdec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
      .addr   (reg_addr),
      .region (region),
      .idx    (idx),
      .ch_ok  (ch_ok)
   );

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         logic       sel;
         logic       pop;
         logic       fl_post;
         logic       new_vld;
         res_flags_t new_flags;

         assign sel          = ch_ok && (idx == IDX_W'(i));
         assign pop          = reg_rd && sel && (region == REG_RESULT);
         assign flush_hit[i] = reg_wr && sel && (region == REG_FLUSH);
         assign fl_post      = flush_hit[i] && (eng_busy[i] || fen[i]);
         assign new_vld      = eng_done[i] || eng_err[i] || fl_post;
         assign new_flags    = '{ovf: 1'b0, err: eng_err[i], fl: fl_post, tpd: eng_done[i]};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ien[i]       <= 1'b0;
               fen[i]       <= 1'b0;
               flush_req[i] <= 1'b0;
            end else begin
               flush_req[i] <= flush_hit[i] && eng_busy[i];
               if (reg_wr && sel && region == REG_CFG) begin
                  ien[i] <= reg_wdata[0];
                  fen[i] <= reg_wdata[1];
               end
            end
         end

         cmpl_chan_slot #(.USE_SHADOW(USE_SHADOW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .new_vld   (new_vld),
            .new_flags (new_flags),
            .pop       (pop),
            .p_vld     (pend[i]),
            .p_flags   (res_flags[i])
         );

         // R6: an abort pulse follows only a flush of a busy channel
         a_r6_abort_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
            flush_req[i] |-> $past(eng_busy[i]));
         // R7: a flush of an idle channel with reporting off posts nothing
         a_r7_idle_flush_silent: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_hit[i] && !eng_busy[i] && !fen[i] && !pend[i]
             && !eng_done[i] && !eng_err[i]) |=> !pend[i]);
      end
   endgenerate

   cmpl_irq_agg #(.NUM_CH(NUM_CH), .IRQ_REG(IRQ_REG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (pend),
      .ien   (ien),
      .irq   (irq)
   );

   always_comb begin
      reg_rdata = '0;
      case (region)
         REG_RESULT: if (ch_ok && pend[idx]) reg_rdata = pack_result(1'b1, res_flags[idx]);
         REG_STATUS: if (ch_ok) reg_rdata[STAT_PEND_BIT] = pend[idx];
         REG_CFG:    if (ch_ok) reg_rdata[1:0] = {fen[idx], ien[idx]};
         REG_AGG:    reg_rdata[NUM_CH-1:0] = pend;
         default:    reg_rdata = '0;
      endcase
   end

   // R6: a single register port can abort at most one channel per cycle
   a_r6_one_abort: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flush_req));

   generate
      if (!IRQ_REG) begin : g_irq_chk
         // R10: no waiting result means no interrupt
         a_r10_idle_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
            (pend == '0) |-> !irq);
      end
   endgenerate
endmodule

// File: tb/tb_cmpl_flush_tracker.sv
`timescale 1ns/1ps
module tb_cmpl_flush_tracker;
   localparam int NCH = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            reg_wr = 1'b0;
   logic            reg_rd = 1'b0;
   logic [11:0]     reg_addr = '0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic [NCH-1:0]  eng_busy = '0;
   logic [NCH-1:0]  eng_done = '0;
   logic [NCH-1:0]  eng_err = '0;
   logic [NCH-1:0]  flush_req;
   logic            irq;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   cmpl_flush_tracker dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eng_busy(eng_busy), .eng_done(eng_done), .eng_err(eng_err),
      .flush_req(flush_req), .irq(irq)
   );

   function automatic logic [11:0] a_res(input int ch);  return 12'(12'h040 + 4*ch); endfunction
   function automatic logic [11:0] a_fl(input int ch);   return 12'(12'h080 + 4*ch); endfunction
   function automatic logic [11:0] a_st(input int ch);   return 12'(12'h200 + 4*ch); endfunction
   function automatic logic [11:0] a_cfg(input int ch);  return 12'(12'h300 + 4*ch); endfunction
   localparam logic [11:0] A_AGG = 12'h380;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic evt(input logic [NCH-1:0] dn, input logic [NCH-1:0] er);
      @(negedge clk);
      eng_done = dn; eng_err = er;
      @(negedge clk);
      eng_done = '0; eng_err = '0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 flush_req", 32'(flush_req), 32'h0);
      rd(A_AGG, d);     chk("R1 aggregate", d, 32'h0);
      rd(a_res(0), d);  chk("R1 result", d, 32'h0);
      rd(a_cfg(0), d);  chk("R1 config", d, 32'h0);
      rd(a_st(15), d);  chk("R1 status", d, 32'h0);
   endtask

   task automatic t_kinds();
      logic [31:0] d;
      evt(16'h0001, 16'h0000);
      rd(a_st(0), d);   chk("R3 status pending", d, 32'h2);
      rd(A_AGG, d);     chk("R3 aggregate bit0", d, 32'h1);
      rd(a_res(0), d);  chk("R2 done word", d, 32'h8000_0002);
      rd(a_st(0), d);   chk("R4 status cleared", d, 32'h0);
      evt(16'h0000, 16'h0001);
      rd(a_res(0), d);  chk("R2 error word", d, 32'h8000_0008);
      evt(16'h0001, 16'h0001);
      rd(a_res(0), d);  chk("R2 done+error word", d, 32'h8000_000A);
      rd(a_res(0), d);  chk("R4 empty read", d, 32'h0);
      rd(A_AGG, d);     chk("R4 aggregate cleared", d, 32'h0);
   endtask

   task automatic t_cfg();
      logic [31:0] d;
      wr(a_cfg(9), 32'hFFFF_FFFF);
      rd(a_cfg(9), d);  chk("R5 config readback", d, 32'h3);
      rd(a_cfg(8), d);  chk("R12 neighbour config", d, 32'h0);
      wr(a_cfg(9), 32'h0000_0000);
      rd(a_cfg(9), d);  chk("R5 config cleared", d, 32'h0);
   endtask

   task automatic t_flush_busy();
      logic [31:0] d;
      eng_busy[2] = 1'b1;
      wr(a_fl(2), 32'h1234_5678);
      chk("R6 flush_req pulse", 32'(flush_req), 32'h0000_0004);
      @(negedge clk);
      chk("R6 flush_req one cycle", 32'(flush_req), 32'h0);
      eng_busy[2] = 1'b0;
      rd(a_res(2), d);  chk("R6 flush word", d, 32'h8000_0004);
   endtask

   task automatic t_flush_idle();
      logic [31:0] d;
      wr(a_fl(6), 32'h0);
      chk("R7 no flush_req idle", 32'(flush_req), 32'h0);
      rd(a_st(6), d);   chk("R7 idle no status", d, 32'h0);
      rd(a_res(6), d);  chk("R7 idle no result", d, 32'h0);
      wr(a_cfg(6), 32'h2);
      wr(a_fl(6), 32'h0);
      chk("R7 no flush_req idle reported", 32'(flush_req), 32'h0);
      rd(a_res(6), d);  chk("R7 idle flush reported", d, 32'h8000_0004);
      wr(a_cfg(6), 32'h0);
   endtask

   task automatic t_shadow();
      logic [31:0] d;
      evt(16'h0008, 16'h0000);
      evt(16'h0000, 16'h0008);
      rd(a_res(3), d);  chk("R8 first in order", d, 32'h8000_0002);
      rd(A_AGG, d);     chk("R8 still pending", d, 32'h0008);
      rd(a_res(3), d);  chk("R8 second in order", d, 32'h8000_0008);
      rd(A_AGG, d);     chk("R4 aggregate after drain", d, 32'h0);
   endtask

   task automatic t_overflow();
      logic [31:0] d;
      evt(16'h0020, 16'h0000);
      evt(16'h0020, 16'h0000);
      evt(16'h0000, 16'h0020);
      rd(a_res(5), d);  chk("R9 readable unchanged", d, 32'h8000_0002);
      rd(a_res(5), d);  chk("R9 overflow marked", d, 32'h8000_001A);
      rd(a_res(5), d);  chk("R9 third not stored", d, 32'h0);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      evt(16'h0080, 16'h0000);
      chk("R10 masked irq low", {31'b0, irq}, 32'h0);
      rd(A_AGG, d);     chk("R10 masked still in aggregate", d, 32'h0080);
      wr(a_cfg(7), 32'h1);
      chk("R10 enabled irq high", {31'b0, irq}, 32'h1);
      rd(a_res(7), d);
      chk("R10 irq low after pop", {31'b0, irq}, 32'h0);
      wr(a_cfg(7), 32'h0);
   endtask

   task automatic t_ignored();
      logic [31:0] d;
      evt(16'h0002, 16'h0000);
      wr(a_res(1), 32'hFFFF_FFFF);
      wr(a_st(1), 32'hFFFF_FFFF);
      wr(A_AGG, 32'hFFFF_FFFF);
      rd(A_AGG, d);     chk("R11 aggregate unchanged", d, 32'h0002);
      rd(a_res(1), d);  chk("R11 result unchanged", d, 32'h8000_0002);
      wr(a_st(4), 32'hFFFF_FFFF);
      rd(a_st(4), d);   chk("R11 status write ignored", d, 32'h0);
   endtask

   task automatic t_indep();
      logic [31:0] d;
      evt(16'h0001, 16'h8000);
      rd(A_AGG, d);     chk("R12 both channels", d, 32'h8001);
      rd(a_res(15), d); chk("R12 channel 15 word", d, 32'h8000_0008);
      rd(A_AGG, d);     chk("R12 channel 0 untouched", d, 32'h0001);
      rd(a_res(0), d);  chk("R12 channel 0 word", d, 32'h8000_0002);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_kinds();
      t_cfg();
      t_flush_busy();
      t_flush_idle();
      t_shadow();
      t_overflow();
      t_irq();
      t_ignored();
      t_indep();
      finish_run();
   end

   initial begin
      #2_000_000;
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      finish_run();
   end
endmodule